// File: doc/BRIEF.md
# Indexed Configuration Port with Key Unlock

This block is the configuration front end of a legacy-style I/O controller. A host reaches it through two byte-wide ports: an index port at a base address and a data port at the next address. The index port selects a configuration register, and the data port reads or writes the selected register. Access stays closed until a fixed key byte has been written to the index port twice in a row. It closes again when a different key byte is written there.

While access is open, one global register holds a logical-device number. That number picks which device's register bank the per-device indices address. Each device bank has an activate register and a window of general configuration bytes. Downstream blocks, such as a watchdog (device 8) or a pin-function unit (device 7), read their bank through a side read port and see their activate bit on a dedicated output. The register contents stay in place across lock and unlock cycles and are cleared only by reset.

Top module: `cfg_index_port`

## Requirements
- R1: Only the index port (BASE_ADDR) and the data port (BASE_ADDR+1) respond. A write to any other address has no effect. `hostRdata` is 0x00 whenever `hostRd` is low or the address hits neither port. Reads are combinational in the same cycle, and writes take effect at the next rising clock edge.
- R2: Configuration mode opens at the clock edge of the second of two consecutive index-port writes of 0x87. An index-port write of any other value while locked restarts the count. Data-port accesses in between do not restart it.
- R3: While open, an index-port write of 0xAA closes configuration mode at that edge. Configuration mode otherwise stays open.
- R4: While open, any other index-port write (0x87 included) loads the index register, and an index-port read returns it. While locked, an index-port read returns 0xFF.
- R5: While locked, data-port writes change no register and data-port reads return 0xFF.
- R6: Index 0x07 is the global logical-device-number register. It accepts any byte and reads back what was written.
- R7: Index 0x30 is the activate register of the selected device. It holds a full byte, and `devActive[d]` equals bit 0 of device d's activate register.
- R8: Indices WIN_BASE to WIN_BASE+WIN_REGS-1 (defaults 0xE0 to 0xFF) form a per-device byte window. Each device keeps its own contents, and the device number selects which window is accessed.
- R9: Indices outside 0x07, 0x30 and the window read 0x00 and ignore writes. When the device number is NUM_DEV or above, the device registers read 0x00 and writes to them are dropped.
- R10: The side port returns the activate register (index 0x30) or the window byte of device `sideDev` at index `sideIdx`. It returns 0x00 for any other index or for an out-of-range device, and it is independent of the lock state.
- R11: Reset clears the lock state, the unlock count, the index, the device number and all device registers to zero. Locking and unlocking leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | ADDR_W | Host address |
| hostWr | input | 1 | Host write strobe, one cycle per access |
| hostRd | input | 1 | Host read strobe |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte, combinational |
| sideDev | input | 8 | Side-port device number |
| sideIdx | input | 8 | Side-port register index |
| sideData | output | 8 | Side-port read byte |
| devActive | output | NUM_DEV | Bit 0 of each device's activate register |

## Verification
The assertions assume that a host access is either a write or a read, never both in one cycle. They also assume that every strobe lasts exactly one clock, so each high cycle counts as one access. The stimulus drives at most one operation per clock, switching inputs on the falling edge, and never raises `hostWr` and `hostRd` together. Random sequences mix unlock keys, lock keys, wrong keys, off-port addresses and out-of-range device numbers. This exercises the unlock counter restarts and the banked decode within those assumptions.

// File: rtl/cfg_index_port_pkg.sv
package cfg_index_port_pkg;
  localparam logic [7:0] KEY_OPEN  = 8'h87;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;
  localparam logic [7:0] IDX_LDN   = 8'h07;
  localparam logic [7:0] IDX_ACT   = 8'h30;

  // strobes from control to datapath
  typedef struct packed {
    logic       open;
    logic [7:0] index;
    logic       dataWr;
    logic       dataRd;
    logic       idxRd;
  } cfgStrobe_t;
endpackage

// File: rtl/cfg_index_port_ctrl.sv
module cfg_index_port_ctrl
  import cfg_index_port_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
  parameter int UNLOCK_WRITES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [7:0]        hostWdata,
  output cfgStrobe_t        strb
);
  localparam int CNT_W = (UNLOCK_WRITES > 2) ? $clog2(UNLOCK_WRITES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(UNLOCK_WRITES - 1);

  logic hitIdx, hitData;
  logic openQ;
  logic [CNT_W-1:0] keyCnt;
  logic [7:0] indexQ;

  assign hitIdx  = (hostAddr == BASE_ADDR);
  assign hitData = (hostAddr == BASE_ADDR + ADDR_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      openQ  <= 1'b0;
      keyCnt <= '0;
      indexQ <= 8'h00;
    end else if (hostWr && hitIdx) begin
      if (!openQ) begin
        if (hostWdata == KEY_OPEN) begin
          if (keyCnt == CNT_LAST) begin
            openQ  <= 1'b1;
            keyCnt <= '0;
          end else begin
            keyCnt <= keyCnt + CNT_W'(1);
          end
        end else begin
          keyCnt <= '0;
        end
      end else if (hostWdata == KEY_CLOSE) begin
        openQ <= 1'b0;
      end else begin
        indexQ <= hostWdata;
      end
    end
  end

  always_comb begin
    strb.open   = openQ;
    strb.index  = indexQ;
    strb.dataWr = hostWr && hitData && openQ;
    strb.dataRd = hostRd && hitData;
    strb.idxRd  = hostRd && hitIdx;
  end
endmodule

// File: rtl/cfg_index_port_dp.sv
module cfg_index_port_dp
  import cfg_index_port_pkg::*;
#(
  parameter int NUM_DEV = 10,
  parameter logic [7:0] WIN_BASE = 8'hE0,
  parameter int WIN_REGS = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         strb,
  input  logic [7:0]         hostWdata,
  input  logic [7:0]         sideDev,
  input  logic [7:0]         sideIdx,
  output logic [7:0]         hostRdata,
  output logic [7:0]         sideData,
  output logic [NUM_DEV-1:0] devActive
);
  localparam int OFF_W   = (WIN_REGS > 1) ? $clog2(WIN_REGS) : 1;
  localparam int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam int WIN_END = int'(WIN_BASE) + WIN_REGS;

  logic [7:0]            ldnQ;
  logic [7:0]            actBus [NUM_DEV];
  logic [WIN_REGS*8-1:0] winBus [NUM_DEV];
  logic [7:0]            dataVal;

  function automatic logic inWin(input logic [7:0] idx);
    return (int'(idx) >= int'(WIN_BASE)) && (int'(idx) < WIN_END);
  endfunction

  function automatic logic [OFF_W-1:0] winOff(input logic [7:0] idx);
    logic [7:0] diff;
    diff = idx - WIN_BASE;
    return diff[OFF_W-1:0];
  endfunction

  function automatic logic [7:0] bankRead(input logic [7:0] dev, input logic [7:0] idx);
    logic [7:0] v;
    v = 8'h00;
    if (int'(dev) < NUM_DEV) begin
      if (idx == IDX_ACT) v = actBus[dev[DEV_W-1:0]];
      else if (inWin(idx)) v = winBus[dev[DEV_W-1:0]][{winOff(idx), 3'b000} +: 8];
    end
    return v;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ldnQ <= 8'h00;
    else if (strb.dataWr && strb.index == IDX_LDN) ldnQ <= hostWdata;
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : gDev
    logic [7:0]            actQ;
    logic [WIN_REGS*8-1:0] winQ;
    logic                  sel;
    assign sel = strb.dataWr && (ldnQ == 8'(d));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        actQ <= 8'h00;
        winQ <= '0;
      end else if (sel) begin
        if (strb.index == IDX_ACT) actQ <= hostWdata;
        else if (inWin(strb.index)) winQ[{winOff(strb.index), 3'b000} +: 8] <= hostWdata;
      end
    end
    assign actBus[d]    = actQ;
    assign winBus[d]    = winQ;
    assign devActive[d] = actQ[0];
  end

  always_comb begin
    if (!strb.open) dataVal = 8'hFF;
    else if (strb.index == IDX_LDN) dataVal = ldnQ;
    else dataVal = bankRead(ldnQ, strb.index);

    if (strb.idxRd) hostRdata = strb.open ? strb.index : 8'hFF;
    else if (strb.dataRd) hostRdata = dataVal;
    else hostRdata = 8'h00;

    sideData = bankRead(sideDev, sideIdx);
  end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfg_index_port_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
  parameter int UNLOCK_WRITES = 2,
  parameter int NUM_DEV = 10,
  parameter logic [7:0] WIN_BASE = 8'hE0,
  parameter int WIN_REGS = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  hostAddr,
  input  logic               hostWr,
  input  logic               hostRd,
  input  logic [7:0]         hostWdata,
  output logic [7:0]         hostRdata,
  input  logic [7:0]         sideDev,
  input  logic [7:0]         sideIdx,
  output logic [7:0]         sideData,
  output logic [NUM_DEV-1:0] devActive
);
  cfgStrobe_t strb;
  logic cfgOpen;
  assign cfgOpen = strb.open;

  cfg_index_port_ctrl #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .UNLOCK_WRITES(UNLOCK_WRITES)
  ) ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostRd(hostRd), .hostWdata(hostWdata), .strb(strb)
  );

  cfg_index_port_dp #(
    .NUM_DEV(NUM_DEV), .WIN_BASE(WIN_BASE), .WIN_REGS(WIN_REGS)
  ) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hostWdata(hostWdata),
    .sideDev(sideDev), .sideIdx(sideIdx), .hostRdata(hostRdata),
    .sideData(sideData), .devActive(devActive)
  );
endmodule

// File: rtl/cfg_index_port_check.sv
module cfg_index_port_check #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
  parameter int NUM_DEV = 10
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  hostAddr,
  input logic               hostWr,
  input logic               hostRd,
  input logic [7:0]         hostWdata,
  input logic [7:0]         hostRdata,
  input logic               cfgOpen,
  input logic [NUM_DEV-1:0] devActive
);
  logic idxWr, dataWr, dataRd;
  assign idxWr  = hostWr && (hostAddr == BASE_ADDR);
  assign dataWr = hostWr && (hostAddr == BASE_ADDR + ADDR_W'(1));
  assign dataRd = hostRd && (hostAddr == BASE_ADDR + ADDR_W'(1));

  assert_idle_read_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    !hostRd |-> hostRdata == 8'h00);

  assert_open_needs_key_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgOpen) |-> $past(idxWr && hostWdata == 8'h87));

  assert_close_key_R3: assert property (@(posedge clk) disable iff (!rstN)
    cfgOpen && idxWr && hostWdata == 8'hAA |=> !cfgOpen);

  assert_stay_open_R3: assert property (@(posedge clk) disable iff (!rstN)
    cfgOpen && !(idxWr && hostWdata == 8'hAA) |=> cfgOpen);

  assert_locked_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    !cfgOpen && dataRd |-> hostRdata == 8'hFF);

  assert_active_by_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(devActive) |-> $past(cfgOpen && dataWr));
endmodule

bind cfg_index_port cfg_index_port_check #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_DEV(NUM_DEV)
) chk (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
  .hostRd(hostRd), .hostWdata(hostWdata), .hostRdata(hostRdata),
  .cfgOpen(cfgOpen), .devActive(devActive)
);

// File: tb/cfg_index_port_test.sv
module cfg_index_port_test;
  localparam int NDEV = 10;
  localparam logic [15:0] PIDX = 16'h03F0;
  localparam logic [15:0] PDAT = 16'h03F1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] hostAddr = '0;
  logic hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0] hostWdata = '0, sideDev = '0, sideIdx = '0;
  logic [7:0] hostRdata, sideData;
  logic [NDEV-1:0] devActive;

  always #5 clk = ~clk;

  cfg_index_port uut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .sideDev(sideDev), .sideIdx(sideIdx),
    .sideData(sideData), .devActive(devActive)
  );

  int vectors = 0, errors = 0;

  // behavioural reference state
  bit mOpen;
  int mCnt;
  logic [7:0] mIdx, mLdn;
  logic [7:0] mAct [NDEV];
  logic [7:0] mWin [NDEV][32];

  task automatic modelClear();
    mOpen = 0; mCnt = 0; mIdx = 0; mLdn = 0;
    for (int d = 0; d < NDEV; d++) begin
      mAct[d] = 0;
      for (int r = 0; r < 32; r++) mWin[d][r] = 0;
    end
  endtask

  function automatic logic [7:0] modelBank(input logic [7:0] dev, input logic [7:0] idx);
    if (dev >= NDEV) return 8'h00;
    if (idx == 8'h30) return mAct[dev];
    if (idx >= 8'hE0) return mWin[dev][idx - 8'hE0];
    return 8'h00;
  endfunction

  function automatic logic [7:0] modelRead(input int kind, input logic [15:0] a);
    if (kind != 2) return 8'h00;
    if (a == PIDX) return mOpen ? mIdx : 8'hFF;
    if (a == PDAT) begin
      if (!mOpen) return 8'hFF;
      if (mIdx == 8'h07) return mLdn;
      return modelBank(mLdn, mIdx);
    end
    return 8'h00;
  endfunction

  task automatic modelWrite(input logic [15:0] a, input logic [7:0] d);
    if (a == PIDX) begin
      if (!mOpen) begin
        if (d == 8'h87) begin
          if (mCnt == 1) begin mOpen = 1; mCnt = 0; end
          else mCnt = 1;
        end else mCnt = 0;
      end else if (d == 8'hAA) mOpen = 0;
      else mIdx = d;
    end else if (a == PDAT && mOpen) begin
      if (mIdx == 8'h07) mLdn = d;
      else if (mLdn < NDEV) begin
        if (mIdx == 8'h30) mAct[mLdn] = d;
        else if (mIdx >= 8'hE0) mWin[mLdn][mIdx - 8'hE0] = d;
      end
    end
  endtask

  task automatic check8(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %02h expected %02h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one host operation: kind 0 idle, 1 write, 2 read
  task automatic op(input int kind, input logic [15:0] a, input logic [7:0] d, input string tag);
    logic [NDEV-1:0] expAct;
    @(negedge clk);
    hostAddr = a; hostWdata = d;
    hostWr = (kind == 1); hostRd = (kind == 2);
    #1;
    for (int i = 0; i < NDEV; i++) expAct[i] = mAct[i][0];
    check8(tag, "hostRdata", hostRdata, modelRead(kind, a));
    vectors++;
    if (devActive !== expAct) begin
      errors++;
      $display("FAIL R7 devActive: got %b expected %b at %0t", devActive, expAct, $time);
    end
    check8("R10", "sideData", sideData, modelBank(sideDev, sideIdx));
    @(posedge clk);
    if (kind == 1) modelWrite(a, d);
  endtask

  task automatic wIdx(input logic [7:0] d, input string tag); op(1, PIDX, d, tag); endtask
  task automatic wDat(input logic [7:0] d, input string tag); op(1, PDAT, d, tag); endtask
  task automatic rIdx(input string tag); op(2, PIDX, 8'h00, tag); endtask
  task automatic rDat(input string tag); op(2, PDAT, 8'h00, tag); endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0; hostWr = 0; hostRd = 0;
    repeat (2) @(negedge clk);
    modelClear();
    rstN = 1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    finishRun();
  end

  initial begin
    modelClear();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R11 reset state, R5/R4 locked reads
    rDat("R5"); rIdx("R4"); op(0, PIDX, 8'h00, "R1");
    wDat(8'h55, "R5");
    // R2 broken key sequence stays locked
    wIdx(8'h87, "R2"); wIdx(8'h55, "R2"); wIdx(8'h87, "R2"); rDat("R2");
    // data access between keys does not restart
    wDat(8'h11, "R2"); wIdx(8'h87, "R2"); rIdx("R2");
    // R6 device number
    wIdx(8'h07, "R4"); rIdx("R4"); wDat(8'h08, "R6"); rDat("R6");
    // R7 activate device 8
    wIdx(8'h30, "R7"); wDat(8'h01, "R7"); rDat("R7");
    // R8 window per device
    wIdx(8'hF2, "R8"); wDat(8'h05, "R8"); rDat("R8");
    wIdx(8'h07, "R8"); wDat(8'h07, "R8");
    wIdx(8'hE6, "R8"); wDat(8'h0A, "R8"); rDat("R8");
    wIdx(8'hF2, "R8"); rDat("R8");
    wIdx(8'h07, "R8"); wDat(8'h08, "R8"); wIdx(8'hF2, "R8"); rDat("R8");
    // R9 unimplemented index and out-of-range device
    wIdx(8'h40, "R9"); wDat(8'h77, "R9"); rDat("R9");
    wIdx(8'h07, "R9"); wDat(8'h0C, "R9"); wIdx(8'h30, "R9"); wDat(8'h01, "R9"); rDat("R9");
    wIdx(8'hE0, "R9"); wDat(8'h33, "R9"); rDat("R9");
    // R1 other address ignored
    op(1, 16'h03F2, 8'hAA, "R1"); op(2, 16'h03F2, 8'h00, "R1"); rIdx("R1");
    // R3 lock, R11 persistence
    wIdx(8'hAA, "R3"); rDat("R3"); rIdx("R3");
    wIdx(8'h87, "R11"); wIdx(8'h87, "R11");
    wIdx(8'h07, "R11"); wDat(8'h08, "R11"); wIdx(8'hF2, "R11"); rDat("R11");
    // R10 side sweep
    for (int d = 0; d < 12; d++) begin
      sideDev = 8'(d); sideIdx = 8'h30; op(0, PIDX, 8'h00, "R10");
      sideIdx = 8'hF2; op(0, PIDX, 8'h00, "R10");
      sideIdx = 8'hE6; op(0, PIDX, 8'h00, "R10");
    end
    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      int sel;
      logic [7:0] idxPick [8];
      idxPick = '{8'h87, 8'hAA, 8'h07, 8'h30, 8'hE0, 8'hFF, 8'h40, 8'hF3};
      sideDev = 8'($urandom_range(0, 11));
      sideIdx = idxPick[$urandom_range(2, 7)];
      sel = $urandom_range(0, 9);
      if (sel < 4) wIdx(idxPick[$urandom_range(0, 7)], "R2");
      else if (sel < 6) wDat(($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 11)) : 8'($urandom), "R8");
      else if (sel < 8) rDat("R8");
      else if (sel < 9) rIdx("R4");
      else op(1, 16'h0000, 8'($urandom), "R1");
    end
    // R11 reset clears everything
    doReset();
    rDat("R11"); wIdx(8'h87, "R11"); wIdx(8'h87, "R11");
    rIdx("R11"); wIdx(8'h07, "R11"); rDat("R11");
    wIdx(8'h30, "R11"); rDat("R11");
    finishRun();
  end
endmodule